// File: doc/BRIEF.md
# Per-Line Trigger-Mode Interrupt Request Latch

This block holds the pending state of eight interrupt request lines for an interrupt controller core. Each line is configured on its own as edge sensitive or level sensitive through a trigger-control register. Raw request levels enter through a two-flop synchroniser. Edge lines latch a pending bit on a rising transition and keep it until the core acknowledges that line. Level lines simply mirror the synchronised input level. The block remembers the last synchronised level of every line so that it can tell a fresh rising transition from an input that is merely still high.

The controller core drives a one-cycle acknowledge strobe with a line index once it has serviced a line, and it reads the 8-bit pending vector every cycle. The trigger-control register has its own write port and is deliberately left untouched by the synchronous controller reset. This lets software set up the line modes once and survive a controller re-initialisation. Lines 0 to 2 have no level capability by default: their mode bits are not implemented, so they always read back as zero.

Top module: `irq_pend_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, the pending vector, the synchroniser flops and the remembered previous levels are all cleared, so `pending` reads 8'h00 one edge after reset is sampled.
- R2: A write (`modeWrEn` high at a clock edge) loads `modeQ` with `modeWrData & 8'hF8` at that edge; bit n of `modeQ` = 1 makes line n level sensitive, and 0 makes it edge sensitive. The lines whose bits are not implemented (0 to 2) read back 0 and always behave as edge lines.
- R3: `modeQ` changes only on a write. It keeps its value across `rst`.
- R4: For a level line, `pending[n]` follows `reqIn[n]` with a latency of three rising edges: an input change driven before edge k shows at `pending` after edge k+2. Acknowledge has no effect on a level line.
- R5: For an edge line, `pending[n]` is set only when the synchronised input is 1 and the remembered previous level is 0. An input held high sets the pending bit once, and it is not set again after an acknowledge until the input falls and rises again.
- R6: For an edge line, a falling input does not clear `pending[n]`.
- R7: An acknowledge (`ackValid` high at an edge, with `ackLine` = n) clears `pending[n]` at that edge if line n is an edge line. It leaves all other lines unchanged.
- R8: If an acknowledge and a new rising edge reach the same edge line in the same cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous controller reset, active high; does not touch the trigger-control register |
| reqIn | input | 8 | Raw, asynchronous request levels, one per line |
| modeWrEn | input | 1 | Write strobe for the trigger-control register |
| modeWrData | input | 8 | Trigger-control write data, 1 = level, 0 = edge |
| ackValid | input | 1 | One-cycle acknowledge strobe from the controller core |
| ackLine | input | 3 | Index of the line being acknowledged |
| pending | output | 8 | Current pending vector |
| modeQ | output | 8 | Trigger-control register read-back |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands in the very cycle a new rising transition on the same edge line leaves the synchroniser. The bench first latches and acknowledges the line, lets the input fall, and then raises it again. It then counts the two synchroniser edges and drives the acknowledge pulse so that it is sampled on the third edge, where the rise is detected. A second hard case is an edge input held high across an acknowledge. The bench holds the level for many cycles after the clear and confirms that no second pending set appears.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int unsigned PL_LINES = 8;
  localparam int unsigned PL_IDX_W = $clog2(PL_LINES);

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // strobes handed from control to datapath for one cycle
  typedef struct packed {
    logic                modeLoad;
    logic [PL_LINES-1:0] ackHot;
  } plStrobe_t;

endpackage

// File: rtl/irq_pend_sync.sv
module irq_pend_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stageQ[s] <= '0;
          else     stageQ[s] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stageQ[s] <= '0;
          else     stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_LINES = PL_LINES,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             modeWrEn,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackLine,
  output plStrobe_t        strb
);

  logic [NUM_LINES-1:0] ackHot;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
      assign ackHot[i] = ackValid && (ackLine == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.modeLoad = modeWrEn;
    strb.ackHot   = ackHot;
  end

endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
#(
  parameter int unsigned          NUM_LINES      = PL_LINES,
  parameter int unsigned          SYNC_STAGES    = 2,
  parameter logic [NUM_LINES-1:0] MODE_IMPL_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] modeWrData,
  input  plStrobe_t            strb,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] modeQ
);

  logic [NUM_LINES-1:0] reqSync;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] pendNext;
  // power-up value only; controller reset leaves this register alone
  logic [NUM_LINES-1:0] modeReg = '0;

  irq_pend_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rawIn   (reqIn),
    .syncOut (reqSync)
  );

  always_ff @(posedge clk) begin
    if (strb.modeLoad) modeReg <= modeWrData & MODE_IMPL_MASK;
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic riseSeen;
      assign riseSeen = reqSync[i] & ~prevQ[i];
      always_comb begin
        if (trig_e'(modeReg[i]) == TRIG_LEVEL) pendNext[i] = reqSync[i];
        else pendNext[i] = riseSeen | (pendQ[i] & ~strb.ackHot[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ <= '0;
      pendQ <= '0;
    end else begin
      prevQ <= reqSync;
      pendQ <= pendNext;
    end
  end

  assign pending = pendQ;
  assign modeQ   = modeReg;

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import irq_pend_pkg::*;
#(
  parameter int unsigned          NUM_LINES      = PL_LINES,
  parameter int unsigned          SYNC_STAGES    = 2,
  parameter logic [NUM_LINES-1:0] MODE_IMPL_MASK = 8'hF8,
  localparam int unsigned         IDX_W          = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 modeWrEn,
  input  logic [NUM_LINES-1:0] modeWrData,
  input  logic                 ackValid,
  input  logic [IDX_W-1:0]     ackLine,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] modeQ
);

  generate
    if (NUM_LINES != PL_LINES) begin : g_bad_width
      $error("NUM_LINES must equal the package line count");
    end
  endgenerate

  plStrobe_t strb;

  irq_pend_ctrl #(
    .NUM_LINES (NUM_LINES)
  ) u_ctrl (
    .modeWrEn (modeWrEn),
    .ackValid (ackValid),
    .ackLine  (ackLine),
    .strb     (strb)
  );

  irq_pend_dp #(
    .NUM_LINES      (NUM_LINES),
    .SYNC_STAGES    (SYNC_STAGES),
    .MODE_IMPL_MASK (MODE_IMPL_MASK)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .reqIn      (reqIn),
    .modeWrData (modeWrData),
    .strb       (strb),
    .pending    (pending),
    .modeQ      (modeQ)
  );

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int unsigned          NUM_LINES      = 8,
  parameter logic [NUM_LINES-1:0] MODE_IMPL_MASK = 8'hF8,
  localparam int unsigned         IDX_W          = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] reqIn,
  input logic                 modeWrEn,
  input logic [NUM_LINES-1:0] modeWrData,
  input logic                 ackValid,
  input logic [IDX_W-1:0]     ackLine,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] modeQ
);

  logic       seen      = 1'b0;
  logic [2:0] sinceRst  = '0;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst)                   sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!seen)
    $past(rst) |-> (pending == '0));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!seen)
    $past(modeWrEn) |-> (modeQ == ($past(modeWrData) & MODE_IMPL_MASK)));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!seen)
    !$past(modeWrEn) |-> $stable(modeQ));

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      // R4
      level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 3'd4 && $past(modeQ[i])) |-> (pending[i] == $past(reqIn[i], 3)));

      // R5
      edge_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 3'd5 && !$past(modeQ[i]) && $rose(pending[i]))
          |-> ($past(reqIn[i], 3) && !$past(reqIn[i], 4)));

      // R7
      edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 3'd2 && !$past(modeQ[i]) && $fell(pending[i]))
          |-> ($past(ackValid) && ($past(ackLine) == IDX_W'(i))));
    end
  endgenerate

endmodule

bind irq_pend_latch irq_pend_chk #(
  .NUM_LINES      (NUM_LINES),
  .MODE_IMPL_MASK (MODE_IMPL_MASK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqIn      (reqIn),
  .modeWrEn   (modeWrEn),
  .modeWrData (modeWrData),
  .ackValid   (ackValid),
  .ackLine    (ackLine),
  .pending    (pending),
  .modeQ      (modeQ)
);

// File: tb/irq_pend_latch_test.sv
module irq_pend_latch_test;

  localparam int CLK_P = 10;

  logic       clk        = 1'b0;
  logic       rst        = 1'b1;
  logic [7:0] reqIn      = '0;
  logic       modeWrEn   = 1'b0;
  logic [7:0] modeWrData = '0;
  logic       ackValid   = 1'b0;
  logic [2:0] ackLine    = '0;
  logic [7:0] pending;
  logic [7:0] modeQ;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_pend_latch uut (
    .clk        (clk),
    .rst        (rst),
    .reqIn      (reqIn),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .ackValid   (ackValid),
    .ackLine    (ackLine),
    .pending    (pending),
    .modeQ      (modeQ)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMode(input logic [7:0] v);
    modeWrEn   = 1'b1;
    modeWrData = v;
    cyc(1);
    modeWrEn   = 1'b0;
  endtask

  task automatic pulseAck(input logic [2:0] line);
    ackValid = 1'b1;
    ackLine  = line;
    cyc(1);
    ackValid = 1'b0;
  endtask

  task automatic t_initial_reset();
    cyc(2);
    check8("R1 pending after reset", pending, 8'h00);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic t_mode_write();
    writeMode(8'hFF);
    check8("R2 unimplemented bits read zero", modeQ, 8'hF8);
    writeMode(8'h07);
    check8("R2 low bits only", modeQ, 8'h00);
    writeMode(8'h5A);
    check8("R2 mixed pattern", modeQ, 8'h58);
    cyc(3);
    check8("R3 mode holds without write", modeQ, 8'h58);
  endtask

  task automatic t_level();
    writeMode(8'h10);
    reqIn[4] = 1'b1;
    cyc(2);
    check8("R4 level not yet through sync", pending, 8'h00);
    cyc(1);
    check8("R4 level set after three edges", pending, 8'h10);
    pulseAck(3'd4);
    check8("R4 ack ignored on level line", pending, 8'h10);
    reqIn[4] = 1'b0;
    cyc(2);
    check8("R4 level clear not yet through", pending, 8'h10);
    cyc(1);
    check8("R4 level clears with input", pending, 8'h00);
  endtask

  task automatic t_edge();
    writeMode(8'h00);
    reqIn[1] = 1'b1;
    cyc(3);
    check8("R5 edge sets pending", pending, 8'h02);
    cyc(10);
    check8("R5 held high keeps single set", pending, 8'h02);
    pulseAck(3'd1);
    check8("R7 ack clears edge line", pending, 8'h00);
    cyc(10);
    check8("R5 held high no second set", pending, 8'h00);
    reqIn[1] = 1'b0;
    cyc(5);
    reqIn[1] = 1'b1;
    cyc(3);
    check8("R5 new rise sets again", pending, 8'h02);
    reqIn[1] = 1'b0;
    cyc(5);
    check8("R6 fall keeps pending", pending, 8'h02);
    pulseAck(3'd1);
    check8("R7 ack after fall clears", pending, 8'h00);
    // line 0 cannot be made level: it must latch like an edge line
    writeMode(8'hFF);
    reqIn[0] = 1'b1;
    cyc(3);
    check8("R2 forced edge line latches", pending, 8'h01);
    pulseAck(3'd0);
    check8("R2 forced edge line clears on ack", pending, 8'h00);
    reqIn[0] = 1'b0;
    cyc(4);
  endtask

  task automatic t_ack_race();
    writeMode(8'h00);
    reqIn[5] = 1'b1;
    cyc(3);
    check8("R5 line five set", pending, 8'h20);
    pulseAck(3'd5);
    reqIn[5] = 1'b0;
    cyc(4);
    check8("R6 line five clear before race", pending, 8'h00);
    reqIn[5] = 1'b1;
    cyc(2);
    pulseAck(3'd5);
    check8("R8 rise wins over same-cycle ack", pending, 8'h20);
    pulseAck(3'd5);
    check8("R7 later ack clears", pending, 8'h00);
    reqIn[5] = 1'b0;
    cyc(4);
  endtask

  task automatic t_mixed_ack();
    writeMode(8'h80);
    reqIn = 8'h82;
    cyc(3);
    check8("R4 R5 mixed lines set", pending, 8'h82);
    pulseAck(3'd7);
    check8("R7 ack on level line no effect", pending, 8'h82);
    pulseAck(3'd1);
    check8("R7 ack touches only its line", pending, 8'h80);
    reqIn = 8'h00;
    cyc(3);
    check8("R4 level line follows low", pending, 8'h00);
  endtask

  task automatic t_reset_keeps_mode();
    writeMode(8'hA8);
    reqIn = 8'h08;
    cyc(3);
    check8("R4 level line three set", pending, 8'h08);
    rst = 1'b1;
    cyc(1);
    check8("R1 reset clears pending", pending, 8'h00);
    check8("R3 mode survives reset", modeQ, 8'hA8);
    cyc(1);
    rst = 1'b0;
    cyc(2);
    check8("R1 sync cleared by reset", pending, 8'h00);
    cyc(1);
    check8("R4 level returns after reset", pending, 8'h08);
    reqIn = 8'h00;
    cyc(4);
  endtask

  initial begin
    #(CLK_P * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_initial_reset();
    t_mode_write();
    t_level();
    t_edge();
    t_ack_race();
    t_mixed_ack();
    t_reset_keeps_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule